// File: doc/BRIEF.md
# Predicated Vector Gather Load Sequencer

This block loads one vector register by gathering 32-bit words from memory. A start pulse hands it a base vector, a 64-bit scalar offset, a byte-granular predicate and an element-size select. The lanes can be 32 or 64 bits wide. For each lane that the predicate enables, the block forms an address: the lane's base element, zero-extended to 64 bits, plus the shared offset. It issues one word read for that address and places the returned word, zero-extended, into the lane. Disabled lanes read nothing and come out as zero. When every lane is handled, a one-cycle done pulse presents the assembled vector.

The memory side is a valid/ready request channel that carries the address and a non-temporal hint bit. Read data comes back on a valid-only response channel, and only one request is in flight at a time. A data-independent-timing input changes how the sequencer moves across lanes. With it set, the sequencer steps through every lane slot in turn, so the cycle count follows the predicate alone and never the data the memory returns.

Top module: `gather_load_seq`

## Requirements
- R1: With size_sel=0 the vector is split into VLEN/32 lanes of 32 bits, lane e at result bits [32e+31:32e]. With size_sel=1 it is split into VLEN/64 lanes of 64 bits, lane e at bits [64e+63:64e].
- R2: The request address for lane e is the zero-extension to 64 bits of base_vec lane e, plus offset, modulo 2^64.
- R3: A disabled lane produces no request, and its result bits are all zero.
- R4: When no lane is enabled, no request is issued, done still pulses, and the result is all zero.
- R5: The returned 32-bit word fills the low 32 bits of its lane. In 64-bit mode the upper 32 bits of the lane are zero.
- R6: Every request is issued with req_nt high.
- R7: Lane e is enabled by pred bit e*4 in 32-bit mode and by pred bit e*8 in 64-bit mode. All other pred bits have no effect.
- R8: Requests are issued in ascending lane order.
- R9: With dit high at start, the number of cycles from start to done is the same for identical predicates, sizes and memory handshake timing, whatever data the memory returns.
- R10: At most one request is outstanding. A request that is not accepted holds its address until req_ready, and no new request appears before the response to the previous one.
- R11: done is a one-cycle pulse, and result changes only in the cycle in which done is high. After reset, done, req_valid and result are zero.
- R12: A start pulse while an operation is in progress is ignored, along with any inputs presented with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| size_sel | input | 1 | Lane width: 0 = 32-bit, 1 = 64-bit |
| dit | input | 1 | Data-independent-timing lane sweep |
| base_vec | input | VLEN | Base address vector |
| offset | input | 64 | Scalar address offset |
| pred | input | VLEN/8 | Predicate, one bit per vector byte |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | 64 | Read address |
| req_nt | output | 1 | Non-temporal hint |
| resp_valid | input | 1 | Read data valid |
| resp_data | input | 32 | Read data word |
| done | output | 1 | Operation complete pulse |
| result | output | VLEN | Assembled vector |

## Verification
The checker watches the memory port on every cycle. It checks that a stalled request holds its address, that no new request follows an accepted one before its response returns, that done never lasts past one cycle, and that result moves only together with done. Several behaviours can be shown only by the bench's scenarios, which compare results against a memory model: address arithmetic and wrap, the choice of which predicate bits enable lanes, ascending lane order, zero-filled and zero-extended lanes, the skip of memory on an empty predicate, rejection of a start while busy, and matching cycle counts for the same predicate over different memory contents.

// File: rtl/gl_pkg.sv
package gl_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 64;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_REQ,
        ST_WAIT
    } gl_state_e;

    typedef enum logic {
        ESZ_32 = 1'b0,
        ESZ_64 = 1'b1
    } gl_esize_e;

    typedef struct packed {
        gl_esize_e esz;
        logic      dit;
    } gl_cfg_t;

    function automatic int lanes_for(input int vlen, input gl_esize_e esz);
        return (esz == ESZ_64) ? vlen / 64 : vlen / 32;
    endfunction

endpackage

// File: rtl/gl_lane_enables.sv
module gl_lane_enables
    import gl_pkg::*;
#(
    parameter int VLEN = 256,
    localparam int NL  = VLEN / WORD_W,
    localparam int PW  = VLEN / 8
) (
    input  logic [PW-1:0] pred,
    input  gl_esize_e     esz,
    output logic [NL-1:0] lane_en
);

    logic [NL-1:0] en32;
    logic [NL-1:0] en64;

    for (genvar e = 0; e < NL; e++) begin : g_w32
        assign en32[e] = pred[e*4];
    end

    for (genvar e = 0; e < NL; e++) begin : g_w64
        if (e < NL / 2) begin : g_live
            assign en64[e] = pred[e*8];
        end else begin : g_dead
            assign en64[e] = 1'b0;
        end
    end

    assign lane_en = (esz == ESZ_64) ? en64 : en32;

endmodule

// File: rtl/gl_pick_lane.sv
module gl_pick_lane #(
    parameter int NL     = 8,
    localparam int IDX_W = $clog2(NL)
) (
    input  logic [NL-1:0]    pending,
    output logic [IDX_W-1:0] idx,
    output logic             found
);

    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = NL - 1; i >= 0; i--) begin
            if (pending[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/gl_lane_addr.sv
module gl_lane_addr
    import gl_pkg::*;
#(
    parameter int VLEN   = 256,
    localparam int NL    = VLEN / WORD_W,
    localparam int IDX_W = $clog2(NL)
) (
    input  logic [VLEN-1:0]   base,
    input  logic [ADDR_W-1:0] off,
    input  gl_esize_e         esz,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);

    logic [WORD_W-1:0] elem32;
    logic [63:0]       elem64;
    logic [ADDR_W-1:0] ext;

    always_comb begin
        elem32 = base[idx*WORD_W +: WORD_W];
        elem64 = base[idx[IDX_W-2:0]*64 +: 64];
        ext    = (esz == ESZ_64) ? elem64 : {{(ADDR_W-WORD_W){1'b0}}, elem32};
        addr   = ext + off;
    end

endmodule

// File: rtl/gather_load_seq.sv
module gather_load_seq
    import gl_pkg::*;
#(
    parameter int VLEN = 256,
    localparam int NL    = VLEN / WORD_W,
    localparam int IDX_W = $clog2(NL),
    localparam int CNT_W = IDX_W + 1,
    localparam int PW    = VLEN / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              size_sel,
    input  logic              dit,
    input  logic [VLEN-1:0]   base_vec,
    input  logic [63:0]       offset,
    input  logic [PW-1:0]     pred,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [63:0]       req_addr,
    output logic              req_nt,
    input  logic              resp_valid,
    input  logic [31:0]       resp_data,
    output logic              done,
    output logic [VLEN-1:0]   result
);

    gl_state_e         state;
    gl_cfg_t           cfg;
    logic [VLEN-1:0]   base_q;
    logic [63:0]       off_q;
    logic [NL-1:0]     pending;
    logic [IDX_W-1:0]  cur;
    logic [CNT_W-1:0]  scan_idx;
    logic [VLEN-1:0]   acc;
    logic [VLEN-1:0]   result_q;
    logic              done_q;

    logic [NL-1:0]     lane_en;
    logic [IDX_W-1:0]  pick_idx;
    logic              pick_found;
    logic [CNT_W-1:0]  lane_limit;
    logic [IDX_W-1:0]  slot;
    logic [IDX_W-1:0]  scan_lane;

    gl_lane_enables #(.VLEN(VLEN)) u_en (
        .pred    (pred),
        .esz     (gl_esize_e'(size_sel)),
        .lane_en (lane_en)
    );

    gl_pick_lane #(.NL(NL)) u_pick (
        .pending (pending),
        .idx     (pick_idx),
        .found   (pick_found)
    );

    gl_lane_addr #(.VLEN(VLEN)) u_addr (
        .base (base_q),
        .off  (off_q),
        .esz  (cfg.esz),
        .idx  (cur),
        .addr (req_addr)
    );

    always_comb begin
        lane_limit = CNT_W'(lanes_for(VLEN, cfg.esz));
        scan_lane  = scan_idx[IDX_W-1:0];
        slot       = (cfg.esz == ESZ_64) ? {cur[IDX_W-2:0], 1'b0} : cur;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cfg      <= '{esz: ESZ_32, dit: 1'b0};
            base_q   <= '0;
            off_q    <= '0;
            pending  <= '0;
            cur      <= '0;
            scan_idx <= '0;
            acc      <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cfg      <= '{esz: gl_esize_e'(size_sel), dit: dit};
                        base_q   <= base_vec;
                        off_q    <= offset;
                        pending  <= lane_en;
                        acc      <= '0;
                        scan_idx <= '0;
                        state    <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (cfg.dit) begin
                        if (scan_idx == lane_limit) begin
                            result_q <= acc;
                            done_q   <= 1'b1;
                            state    <= ST_IDLE;
                        end else if (pending[scan_lane]) begin
                            cur   <= scan_lane;
                            state <= ST_REQ;
                        end else begin
                            scan_idx <= scan_idx + 1'b1;
                        end
                    end else begin
                        if (pick_found) begin
                            cur   <= pick_idx;
                            state <= ST_REQ;
                        end else begin
                            result_q <= acc;
                            done_q   <= 1'b1;
                            state    <= ST_IDLE;
                        end
                    end
                end
                ST_REQ: begin
                    if (req_ready) begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (resp_valid) begin
                        acc[slot*WORD_W +: WORD_W] <= resp_data;
                        pending[cur]               <= 1'b0;
                        scan_idx                   <= CNT_W'(cur) + 1'b1;
                        state                      <= ST_SCAN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_valid = (state == ST_REQ);
    assign req_nt    = 1'b1;
    assign done      = done_q;
    assign result    = result_q;

endmodule

// File: rtl/gl_checker.sv
module gl_checker #(
    parameter int VLEN = 256
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic [63:0]     req_addr,
    input logic            resp_valid,
    input logic            done,
    input logic [VLEN-1:0] result
);

    logic outstanding;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding <= 1'b0;
        end else if (req_valid && req_ready) begin
            outstanding <= 1'b1;
        end else if (resp_valid) begin
            outstanding <= 1'b0;
        end
    end

    // R10: a stalled request keeps its address
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

    // R10: an accepted request is not followed at once by another
    p_gap_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_valid);

    // R10: no request while one is awaiting its response
    p_single_r10: assert property (@(posedge clk) disable iff (rst)
        outstanding |-> !req_valid);

    // R11: done lasts one cycle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: result moves only alongside done
    p_result_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> done);

endmodule

bind gather_load_seq gl_checker #(.VLEN(VLEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .resp_valid (resp_valid),
    .done       (done),
    .result     (result)
);

// File: tb/tb_gather_load_seq.sv
`timescale 1ns/1ps
module tb_gather_load_seq;

    localparam int VLEN = 256;
    localparam int PW   = VLEN / 8;

    logic            clk = 1'b0;
    logic            rst;
    logic            start;
    logic            size_sel;
    logic            dit;
    logic [VLEN-1:0] base_vec;
    logic [63:0]     offset;
    logic [PW-1:0]   pred;
    logic            req_valid;
    logic            req_ready;
    logic [63:0]     req_addr;
    logic            req_nt;
    logic            resp_valid;
    logic [31:0]     resp_data;
    logic            done;
    logic [VLEN-1:0] result;

    always #4 clk = ~clk;

    gather_load_seq #(.VLEN(VLEN)) dut (
        .clk(clk), .rst(rst), .start(start), .size_sel(size_sel), .dit(dit),
        .base_vec(base_vec), .offset(offset), .pred(pred),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_nt(req_nt), .resp_valid(resp_valid), .resp_data(resp_data),
        .done(done), .result(result)
    );

    int n_checks = 0;
    int n_err    = 0;

    // memory model state
    int          lat_cfg   = 1;
    bit          rnd_ready = 1'b0;
    int          wait_cnt  = 0;
    logic [63:0] pend_addr;
    logic [31:0] salt      = 32'h0;
    logic [63:0] log_addr [16];
    logic        log_nt   [16];
    int          n_req     = 0;
    int          done_cnt  = 0;
    logic [VLEN-1:0] got_result;

    function automatic logic [31:0] mem_word(input logic [63:0] a, input logic [31:0] s);
        return a[31:0] ^ {a[47:32], a[63:48]} ^ s ^ 32'hA5C3_0F1E;
    endfunction

    function automatic bit lane_on(input bit esz, input logic [PW-1:0] p, input int e);
        return esz ? p[e*8] : p[e*4];
    endfunction

    function automatic logic [63:0] lane_addr(input bit esz, input logic [VLEN-1:0] b,
                                              input logic [63:0] o, input int e);
        logic [63:0] x;
        x = esz ? b[e*64 +: 64] : {32'h0, b[e*32 +: 32]};
        return x + o;
    endfunction

    function automatic logic [VLEN-1:0] exp_result(input bit esz, input logic [VLEN-1:0] b,
            input logic [63:0] o, input logic [PW-1:0] p, input logic [31:0] s);
        logic [VLEN-1:0] r;
        int nl;
        r  = '0;
        nl = esz ? VLEN / 64 : VLEN / 32;
        for (int e = 0; e < nl; e++) begin
            if (lane_on(esz, p, e)) begin
                if (esz) r[e*64 +: 64] = {32'h0, mem_word(lane_addr(esz, b, o, e), s)};
                else     r[e*32 +: 32] = mem_word(lane_addr(esz, b, o, e), s);
            end
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    always @(negedge clk) begin
        if (rst) begin
            req_ready  = 1'b0;
            resp_valid = 1'b0;
            wait_cnt   = 0;
        end else begin
            resp_valid = 1'b0;
            if (wait_cnt > 0) begin
                wait_cnt--;
                if (wait_cnt == 0) begin
                    resp_valid = 1'b1;
                    resp_data  = mem_word(pend_addr, salt);
                end
            end
            req_ready = rnd_ready ? ($urandom % 2 == 1) : 1'b1;
            if (req_valid && req_ready) begin
                if (n_req < 16) begin
                    log_addr[n_req] = req_addr;
                    log_nt[n_req]   = req_nt;
                end
                n_req++;
                pend_addr = req_addr;
                wait_cnt  = lat_cfg;
            end
            if (done) done_cnt++;
        end
    end

    task automatic run_op(input bit esz, input bit d, input logic [VLEN-1:0] b,
                          input logic [63:0] o, input logic [PW-1:0] p,
                          input bit inject, output int cyc);
        @(negedge clk);
        n_req    = 0;
        done_cnt = 0;
        size_sel = esz;
        dit      = d;
        base_vec = b;
        offset   = o;
        pred     = p;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc   = 1;
        while (!done && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (inject && cyc == 3) begin
                base_vec = ~b;
                pred     = ~p;
                size_sel = ~esz;
                start    = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start      = 1'b0;
        got_result = result;
        chk(done, "R11", "done seen", VLEN'(done), VLEN'(1));
        @(negedge clk);
        chk(!done, "R11", "done single cycle", VLEN'(done), VLEN'(0));
    endtask

    task automatic verify(input bit esz, input logic [VLEN-1:0] b, input logic [63:0] o,
                          input logic [PW-1:0] p, input logic [31:0] s, input string tag);
        int nl;
        int k;
        bit addr_ok;
        bit nt_ok;
        logic [63:0] bad_a;
        logic [63:0] bad_e;
        logic [VLEN-1:0] er;
        nl = esz ? VLEN / 64 : VLEN / 32;
        k = 0;
        addr_ok = 1'b1;
        nt_ok = 1'b1;
        bad_a = '0;
        bad_e = '0;
        for (int e = 0; e < nl; e++) begin
            if (lane_on(esz, p, e)) begin
                if (k < 16 && k < n_req && log_addr[k] !== lane_addr(esz, b, o, e) && addr_ok) begin
                    addr_ok = 1'b0;
                    bad_a = log_addr[k];
                    bad_e = lane_addr(esz, b, o, e);
                end
                k++;
            end
        end
        for (int i = 0; i < n_req && i < 16; i++) if (log_nt[i] !== 1'b1) nt_ok = 1'b0;
        // R3 / R4 / R7: one read per enabled lane, none otherwise
        chk(n_req == k, "R3", {tag, " request count"}, VLEN'(n_req), VLEN'(k));
        // R2 / R8: addresses in ascending lane order
        chk(addr_ok, "R2", {tag, " address/order R8"}, VLEN'(bad_a), VLEN'(bad_e));
        // R6: hint on every request
        chk(nt_ok, "R6", {tag, " non-temporal hint"}, VLEN'(nt_ok), VLEN'(1));
        // R1 / R5: lane layout and zero-extension
        er = exp_result(esz, b, o, p, s);
        chk(got_result === er, "R1", {tag, " result R5"}, got_result, er);
    endtask

    function automatic logic [VLEN-1:0] rnd_vec();
        logic [VLEN-1:0] v;
        for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        #(8 * 150000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int cyc;
        int cyc_a;
        int cyc_b;
        logic [VLEN-1:0] b;
        logic [63:0] o;
        logic [PW-1:0] p;
        logic [31:0] bogus;
        bogus = $urandom(32'd20240611);
        rst = 1'b1; start = 1'b0; size_sel = 1'b0; dit = 1'b0;
        base_vec = '0; offset = '0; pred = '0;
        req_ready = 1'b0; resp_valid = 1'b0; resp_data = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk(done === 1'b0 && req_valid === 1'b0, "R11", "reset outputs",
            VLEN'({done, req_valid}), VLEN'(0));
        chk(result === '0, "R11", "reset result", result, '0);

        // R1: all 32-bit lanes active
        for (int i = 0; i < 8; i++) b[i*32 +: 32] = 32'h1000_0000 + i * 32'h40;
        o = 64'h0000_0001_0000_1000; p = 32'h1111_1111; salt = 32'h1;
        run_op(1'b0, 1'b0, b, o, p, 1'b0, cyc);
        verify(1'b0, b, o, p, salt, "all32");

        // R1 / R5: all 64-bit lanes active, high base bits set
        for (int i = 0; i < 4; i++) b[i*64 +: 64] = 64'hFFFF_0000_0000_0000 + i * 64'h100;
        o = 64'h10; p = 32'h0101_0101; salt = 32'hFFFF_FFFF;
        run_op(1'b1, 1'b0, b, o, p, 1'b0, cyc);
        verify(1'b1, b, o, p, salt, "all64");

        // R4: nothing enabled
        b = rnd_vec(); p = '0;
        run_op(1'b0, 1'b0, b, o, p, 1'b0, cyc);
        chk(n_req == 0, "R4", "empty predicate reads", VLEN'(n_req), VLEN'(0));
        chk(got_result === '0, "R4", "empty predicate result", got_result, '0);

        // R7: only non-leading predicate bits set
        run_op(1'b0, 1'b0, b, o, 32'hEEEE_EEEE, 1'b0, cyc);
        chk(n_req == 0 && got_result === '0, "R7", "32-bit ignored bits",
            VLEN'(n_req), VLEN'(0));
        run_op(1'b1, 1'b1, b, o, 32'hFEFE_FEFE, 1'b0, cyc);
        chk(n_req == 0 && got_result === '0, "R7", "64-bit ignored bits",
            VLEN'(n_req), VLEN'(0));
        run_op(1'b1, 1'b0, b, o, 32'h0F01_F0FF, 1'b0, cyc);
        verify(1'b1, b, o, 32'h0F01_F0FF, salt, "R7 mixed64");

        // R2: address wrap
        b = rnd_vec(); b[63:0] = 64'hFFFF_FFFF_FFFF_FFFF; o = 64'h5;
        run_op(1'b1, 1'b0, b, o, 32'h0000_0001, 1'b0, cyc);
        chk(n_req == 1 && log_addr[0] === 64'h4, "R2", "wrap address",
            VLEN'(log_addr[0]), VLEN'(64'h4));

        // R8 / R3: sparse lanes 1, 4, 7
        b = rnd_vec(); o = 64'h0000_0000_FFFF_FFF0;
        run_op(1'b0, 1'b0, b, o, 32'h1001_0010, 1'b0, cyc);
        verify(1'b0, b, o, 32'h1001_0010, salt, "R8 sparse");

        // R12: start while busy
        lat_cfg = 3;
        b = rnd_vec(); o = 64'h200; p = 32'h1111_1111;
        run_op(1'b0, 1'b0, b, o, p, 1'b1, cyc);
        verify(1'b0, b, o, p, salt, "R12 busy");
        repeat (20) @(negedge clk);
        chk(done_cnt == 1 && n_req == 8, "R12", "no second operation",
            VLEN'(done_cnt), VLEN'(1));

        // R9: timing independent of memory data under dit
        lat_cfg = 2;
        rnd_ready = 1'b0;
        for (int t = 0; t < 6; t++) begin
            bit esz;
            esz = t[0];
            b = rnd_vec(); o = {$urandom, $urandom}; p = $urandom;
            salt = $urandom;
            run_op(esz, 1'b1, b, o, p, 1'b0, cyc_a);
            verify(esz, b, o, p, salt, "R9 run a");
            salt = ~salt;
            run_op(esz, 1'b1, b, o, p, 1'b0, cyc_b);
            verify(esz, b, o, p, salt, "R9 run b");
            chk(cyc_a == cyc_b, "R9", "dit cycle count", VLEN'(cyc_b), VLEN'(cyc_a));
        end

        // random mix
        for (int t = 0; t < 40; t++) begin
            bit esz;
            bit d;
            esz = $urandom % 2;
            d = $urandom % 2;
            rnd_ready = $urandom % 2;
            lat_cfg = 1 + $urandom % 3;
            salt = $urandom;
            b = rnd_vec(); o = {$urandom, $urandom};
            p = $urandom & $urandom;
            run_op(esz, d, b, o, p, 1'b0, cyc);
            verify(esz, b, o, p, salt, "random");
        end

        summary();
        $finish;
    end

endmodule